// File: doc/BRIEF.md
# Stacked-Bus to Shared-Memory Bridge

This block sits between a 16-bit ISA-style embedded expansion bus and one port of a 64K x 16 shared memory. It also carries a simple interrupt handshake between the host on that bus and a DSP on the other side of the memory.

On the bus, the low twenty address lines stay valid for the whole cycle. The top four lines are valid only around the address-latch-enable strobe, so the bridge holds them in a register. It then decodes a 128 KB window that starts at 100000H, just above the first megabyte. Bus address bits 16..1 go out as the memory word address, and the bridge drives chip select, output enable and write enable while a memory strobe hits the window.

For the handshake, the two DSP flag outputs are passed through a register onto two host interrupt lines. A host I/O write to either of two configured port addresses produces a fixed-length reply pulse on the matching DSP interrupt input. The host writes to the first port once it has filled the memory, and to the second port once it has drained it.

Top module: `isa_shram_bridge`

## Requirements
- R1: While rst_ni is low, mem_cs_n_o, mem_oe_n_o and mem_we_n_o are 1, host_irq_o and dsp_irq_o are 0, and the held upper address is 0.
- R2: The held upper address takes the value of la_hi_i at the first clock edge where bale_i is sampled 0 after having been sampled 1. At every other edge it keeps its value, so changes on la_hi_i outside that edge do not affect decoding.
- R3: mem_addr_o equals sa_i[16:1] at all times. sa_i[0] is not used.
- R4: The access hits the window when {held upper address, sa_i[19:17]} equals 7'b0001000, which is byte address 100000H..11FFFFH. mem_cs_n_o is 0 exactly when the access hits and memr_n_i or memw_n_i is 0.
- R5: When the access misses the window, mem_cs_n_o, mem_oe_n_o and mem_we_n_o all stay 1, whatever the strobes are.
- R6: mem_oe_n_o is 0 exactly when the access hits and memr_n_i is 0. mem_we_n_o is 0 exactly when the access hits and memw_n_i is 0.
- R7: host_irq_o[k] equals dsp_flag_i[k] as sampled at the previous clock edge, for k = 0 and 1.
- R8: When iow_n_i is sampled 0 after having been sampled 1, and sa_i[15:0] equals 0300H, dsp_irq_o[0] is 1 for exactly 4 clocks starting at that edge. Port 0302H does the same for dsp_irq_o[1]. A write to any other port produces no pulse.
- R9: A matching I/O write that arrives while its pulse is still active restarts that pulse at its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge clock; bus inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bale_i | input | 1 | Address-latch-enable strobe, active high |
| la_hi_i | input | 4 | Unlatched upper address lines 23..20 |
| sa_i | input | 20 | Latched address lines 19..0 |
| memr_n_i | input | 1 | Memory read strobe, active low |
| memw_n_i | input | 1 | Memory write strobe, active low |
| iow_n_i | input | 1 | I/O write strobe, active low |
| dsp_flag_i | input | 2 | DSP flags: bit 0 requests data, bit 1 reports read data ready |
| mem_addr_o | output | 16 | Memory word address |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| host_irq_o | output | 2 | Host interrupt lines relayed from the DSP flags |
| dsp_irq_o | output | 2 | Reply interrupts to the DSP: bit 0 after a host write, bit 1 after a host read |

## Verification
The hardest case to reach is a stale upper address. The address-latch strobe has already fallen, and la_hi_i then changes in the middle of a memory cycle. A bridge that samples the lines continuously instead of holding them would only show the error in its decode. The bench therefore drives a bus cycle whose upper lines swing between an in-window and an out-of-window value while the strobe stays low. It also runs cycles where the strobe falls at the moment the lines change.

The restart of a reply pulse needs a second I/O write edge to arrive before the first pulse has ended. The bench places that second edge two clocks into the first pulse and counts the length of the combined pulse.

// File: rtl/isa_bridge_pkg.sv
`timescale 1ns/1ps
package isa_bridge_pkg;
  localparam int unsigned N_REPLY = 2;

  typedef struct packed {
    logic rd;
    logic wr;
  } mem_req_t;
endpackage

// File: rtl/addr_latch_dec.sv
`timescale 1ns/1ps
module addr_latch_dec
  import isa_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned LATCH_LSB = 20,
  parameter int unsigned WIN_LOG2  = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'h100000,
  localparam int unsigned HI_W = ADDR_W - LATCH_LSB,
  localparam int unsigned WA_W = WIN_LOG2 - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bale_i,
  input  logic [HI_W-1:0]      la_hi_i,
  input  logic [LATCH_LSB-1:0] sa_i,
  input  mem_req_t             req_i,
  output logic [HI_W-1:0]      la_q_o,
  output logic [WA_W-1:0]      word_addr_o,
  output logic                 cs_n_o,
  output logic                 oe_n_o,
  output logic                 we_n_o
);
  logic            bale_q;
  logic [HI_W-1:0] la_q;
  logic            hit;

  // capture on the strobe's falling edge, hold until the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bale_q <= 1'b0;
      la_q   <= '0;
    end else begin
      bale_q <= bale_i;
      if (bale_q && !bale_i) la_q <= la_hi_i;
    end
  end

  always_comb begin
    hit         = ({la_q, sa_i} >> WIN_LOG2) == (WIN_BASE >> WIN_LOG2);
    word_addr_o = sa_i[WIN_LOG2-1:1];
    cs_n_o      = !(hit && (req_i.rd || req_i.wr));
    oe_n_o      = !(hit && req_i.rd);
    we_n_o      = !(hit && req_i.wr);
  end

  assign la_q_o = la_q;
endmodule

// File: rtl/reply_pulse.sv
`timescale 1ns/1ps
module reply_pulse #(
  parameter int unsigned PULSE_LEN = 4,
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i)         cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/dsp_handshake.sv
`timescale 1ns/1ps
module dsp_handshake
  import isa_bridge_pkg::*;
#(
  parameter int unsigned IO_W      = 16,
  parameter int unsigned PULSE_LEN = 4,
  parameter logic [N_REPLY*IO_W-1:0] PORTS = {16'h0302, 16'h0300}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               iow_n_i,
  input  logic [IO_W-1:0]    io_addr_i,
  input  logic [N_REPLY-1:0] flag_i,
  output logic [N_REPLY-1:0] host_irq_o,
  output logic [N_REPLY-1:0] reply_o
);
  logic iow_q;
  logic wr_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iow_q      <= 1'b1;
      host_irq_o <= '0;
    end else begin
      iow_q      <= iow_n_i;
      host_irq_o <= flag_i;
    end
  end

  assign wr_edge = iow_q && !iow_n_i;

  for (genvar k = 0; k < N_REPLY; k++) begin : g_reply
    logic fire;
    assign fire = wr_edge && (io_addr_i == PORTS[k*IO_W +: IO_W]);
    reply_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire),
      .pulse_o(reply_o[k])
    );
  end
endmodule

// File: rtl/isa_shram_bridge.sv
`timescale 1ns/1ps
module isa_shram_bridge
  import isa_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned LATCH_LSB = 20,
  parameter int unsigned WIN_LOG2  = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'h100000,
  parameter int unsigned IO_W      = 16,
  parameter logic [IO_W-1:0] PORT_FILL  = 16'h0300,
  parameter logic [IO_W-1:0] PORT_DRAIN = 16'h0302,
  parameter int unsigned PULSE_LEN = 4,
  localparam int unsigned HI_W = ADDR_W - LATCH_LSB,
  localparam int unsigned WA_W = WIN_LOG2 - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bale_i,
  input  logic [HI_W-1:0]      la_hi_i,
  input  logic [LATCH_LSB-1:0] sa_i,
  input  logic                 memr_n_i,
  input  logic                 memw_n_i,
  input  logic                 iow_n_i,
  input  logic [1:0]           dsp_flag_i,
  output logic [WA_W-1:0]      mem_addr_o,
  output logic                 mem_cs_n_o,
  output logic                 mem_oe_n_o,
  output logic                 mem_we_n_o,
  output logic [1:0]           host_irq_o,
  output logic [1:0]           dsp_irq_o
);
  mem_req_t        req;
  logic [HI_W-1:0] la_q;

  assign req.rd = !memr_n_i;
  assign req.wr = !memw_n_i;

  addr_latch_dec #(
    .ADDR_W   (ADDR_W),
    .LATCH_LSB(LATCH_LSB),
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bale_i     (bale_i),
    .la_hi_i    (la_hi_i),
    .sa_i       (sa_i),
    .req_i      (req),
    .la_q_o     (la_q),
    .word_addr_o(mem_addr_o),
    .cs_n_o     (mem_cs_n_o),
    .oe_n_o     (mem_oe_n_o),
    .we_n_o     (mem_we_n_o)
  );

  dsp_handshake #(
    .IO_W     (IO_W),
    .PULSE_LEN(PULSE_LEN),
    .PORTS    ({PORT_DRAIN, PORT_FILL})
  ) u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .iow_n_i   (iow_n_i),
    .io_addr_i (sa_i[IO_W-1:0]),
    .flag_i    (dsp_flag_i),
    .host_irq_o(host_irq_o),
    .reply_o   (dsp_irq_o)
  );
endmodule

// File: rtl/isa_shram_bridge_chk.sv
`timescale 1ns/1ps
module isa_shram_bridge_chk #(
  parameter int unsigned IO_W = 16,
  parameter logic [IO_W-1:0] PORT_FILL = 16'h0300
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bale_i,
  input logic [3:0]      la_q,
  input logic [19:0]     sa_i,
  input logic            memr_n_i,
  input logic            memw_n_i,
  input logic            iow_n_i,
  input logic [1:0]      dsp_flag_i,
  input logic            mem_cs_n_o,
  input logic            mem_oe_n_o,
  input logic            mem_we_n_o,
  input logic [1:0]      host_irq_o,
  input logic [1:0]      dsp_irq_o
);
  // R4
  cs_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_n_o |-> (!memr_n_i || !memw_n_i));
  // R5
  cs_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_n_o |-> ({la_q, sa_i[19:17]} == 7'b0001000));
  // R6
  we_under_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o || !mem_oe_n_o) |-> !mem_cs_n_o);
  // R2
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bale_i && !$fell(bale_i) |=> $stable(la_q));
  // R7
  flag_relay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> host_irq_o == $past(dsp_flag_i));
  // R8
  reply_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iow_n_i) && (sa_i[IO_W-1:0] == PORT_FILL) |=> dsp_irq_o[0]);
endmodule

bind isa_shram_bridge isa_shram_bridge_chk #(.IO_W(IO_W), .PORT_FILL(PORT_FILL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bale_i    (bale_i),
  .la_q      (la_q),
  .sa_i      (sa_i),
  .memr_n_i  (memr_n_i),
  .memw_n_i  (memw_n_i),
  .iow_n_i   (iow_n_i),
  .dsp_flag_i(dsp_flag_i),
  .mem_cs_n_o(mem_cs_n_o),
  .mem_oe_n_o(mem_oe_n_o),
  .mem_we_n_o(mem_we_n_o),
  .host_irq_o(host_irq_o),
  .dsp_irq_o (dsp_irq_o)
);

// File: tb/sim_isa_shram_bridge.sv
`timescale 1ns/1ps
module sim_isa_shram_bridge;
  localparam int PL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bale = 1'b0;
  logic [3:0]  la_hi = '0;
  logic [19:0] sa = '0;
  logic        memr_n = 1'b1, memw_n = 1'b1, iow_n = 1'b1;
  logic [1:0]  flag = '0;
  logic [15:0] mem_addr;
  logic        cs_n, oe_n, we_n;
  logic [1:0]  host_irq, dsp_irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_la = 0, m_bale = 0, m_iow = 1;
  int m_hirq = 0;
  int m_cnt [2] = '{0, 0};

  always #2.5 clk = ~clk;

  isa_shram_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .bale_i(bale), .la_hi_i(la_hi), .sa_i(sa),
    .memr_n_i(memr_n), .memw_n_i(memw_n), .iow_n_i(iow_n), .dsp_flag_i(flag),
    .mem_addr_o(mem_addr), .mem_cs_n_o(cs_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .host_irq_o(host_irq), .dsp_irq_o(dsp_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_la = 0; m_bale = 0; m_iow = 1; m_hirq = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      bit edge_w;
      if (m_bale == 1 && bale == 1'b0) m_la = int'(la_hi);
      m_bale = int'(bale);
      edge_w = (m_iow == 1) && (iow_n == 1'b0);
      for (int k = 0; k < 2; k++) begin
        if (edge_w && sa[15:0] == (k == 0 ? 16'h0300 : 16'h0302)) m_cnt[k] = PL;
        else if (m_cnt[k] > 0) m_cnt[k] = m_cnt[k] - 1;
      end
      m_iow = int'(iow_n);
      m_hirq = int'(flag);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit hit;
      int e_cs, e_oe, e_we, e_irq;
      hit = (m_la == 1) && (sa[19:17] == 3'd0);
      e_cs = !(hit && (!memr_n || !memw_n));
      e_oe = !(hit && !memr_n);
      e_we = !(hit && !memw_n);
      e_irq = (m_cnt[1] > 0 ? 2 : 0) | (m_cnt[0] > 0 ? 1 : 0);
      chk(mem_addr == sa[16:1], "R3 addr", mem_addr, sa[16:1]);
      chk(int'(cs_n) == e_cs, hit ? "R4 cs" : "R5 cs", cs_n, e_cs);
      chk(int'(oe_n) == e_oe, "R6 oe", oe_n, e_oe);
      chk(int'(we_n) == e_we, "R6 we", we_n, e_we);
      chk(int'(host_irq) == m_hirq, "R7 host_irq", host_irq, m_hirq);
      chk(int'(dsp_irq) == e_irq, "R8 dsp_irq", dsp_irq, e_irq);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic addr_phase(input logic [3:0] hi, input logic [19:0] a);
    la_hi = hi; sa = a; bale = 1'b1;
    step();
    bale = 1'b0;
    step();
  endtask

  task automatic mem_cyc(input bit wr, input int len);
    if (wr) memw_n = 1'b0; else memr_n = 1'b0;
    step(len);
    memr_n = 1'b1; memw_n = 1'b1;
    step();
  endtask

  // counts observed pulse cycles; retrig places a second edge two clocks in
  task automatic io_pulse(input logic [15:0] port, input int ch, input bit retrig, output int n);
    n = 0;
    sa = {4'h0, port}; iow_n = 1'b0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (dsp_irq[ch]) n++;
      #1;
      if (i == 0) iow_n = 1'b1;
      if (retrig && i == 1) iow_n = 1'b0;
      if (retrig && i == 2) iow_n = 1'b1;
    end
    sa = '0;
  endtask

  initial begin : watchdog
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    step(3);
    // R1 reset state
    chk(cs_n && oe_n && we_n, "R1 strobes idle", {cs_n, oe_n, we_n}, 3'b111);
    chk(host_irq == 2'b00 && dsp_irq == 2'b00, "R1 irqs", {host_irq, dsp_irq}, 0);
    memr_n = 1'b0; sa = 20'h00010;
    step();
    chk(cs_n == 1'b1, "R1 upper held 0 so no hit", cs_n, 1);
    memr_n = 1'b1;
    rst_n = 1'b1;
    step(2);

    // in-window read and write
    addr_phase(4'h1, 20'h0ABCE);
    mem_cyc(1'b0, 2);
    addr_phase(4'h1, 20'h1FFFE);
    memw_n = 1'b0;
    step();
    chk(we_n == 1'b0 && cs_n == 1'b0, "R6 write in window", {cs_n, we_n}, 0);
    chk(mem_addr == 16'hFFFF, "R3 top word", mem_addr, 16'hFFFF);
    memw_n = 1'b1;
    step();

    // outside: wrong upper nibble, and upper ok but sa[19:17] nonzero
    addr_phase(4'h2, 20'h00100);
    mem_cyc(1'b0, 2);
    addr_phase(4'h1, 20'h20000);
    memr_n = 1'b0;
    step();
    chk(cs_n && oe_n && we_n, "R5 miss above window", {cs_n, oe_n, we_n}, 3'b111);
    memr_n = 1'b1;
    step();
    addr_phase(4'h0, 20'hF0000);
    mem_cyc(1'b1, 2);

    // R2: upper lines move while strobe is low
    addr_phase(4'h1, 20'h00040);
    la_hi = 4'h7;
    memr_n = 1'b0;
    step();
    chk(cs_n == 1'b0, "R2 held upper survives change", cs_n, 0);
    la_hi = 4'h1;
    memr_n = 1'b1;
    step();
    addr_phase(4'h3, 20'h00040);
    la_hi = 4'h1;
    memr_n = 1'b0;
    step();
    chk(cs_n == 1'b1, "R2 late in-window value ignored", cs_n, 1);
    memr_n = 1'b1;
    step();
    // R3: sa[0] unused
    sa = 20'h00041;
    step();
    chk(mem_addr == 16'h0020, "R3 bit0 dropped", mem_addr, 16'h0020);

    // R7 flag relay
    flag = 2'b01; step();
    flag = 2'b10; step();
    chk(host_irq == 2'b10, "R7 flag1 relay", host_irq, 2'b10);
    flag = 2'b11; step(2);
    flag = 2'b00; step(2);

    // R8 pulses
    io_pulse(16'h0300, 0, 1'b0, n);
    chk(n == PL, "R8 fill pulse length", n, PL);
    io_pulse(16'h0302, 1, 1'b0, n);
    chk(n == PL, "R8 drain pulse length", n, PL);
    io_pulse(16'h0304, 0, 1'b0, n);
    chk(n == 0, "R8 other port no pulse", n, 0);
    io_pulse(16'h0302, 0, 1'b0, n);
    chk(n == 0, "R8 drain port leaves ch0", n, 0);
    // R9 restart
    io_pulse(16'h0300, 0, 1'b1, n);
    chk(n == PL + 2, "R9 restart length", n, PL + 2);

    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      addr_phase(4'((i % 3 == 0) ? 2 : 1), 20'((i * 20'h0D37A) & 20'h3FFFF));
      flag = 2'(i);
      mem_cyc(1'(i % 2), 1 + i % 3);
    end
    step(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule